// File: doc/BRIEF.md
# Dual-Group Programmable Clock Divider with Relative Phase Offset

This block divides one fast input clock into two output clocks, one per output group. Each group picks its own division ratio from a fixed table of eleven values. The rising edge of the second group can be delayed relative to the first group in whole phase steps. A step lasts five input cycles when the chosen ratio is a multiple of five and one input cycle otherwise, so a ratio of R offers R/5 or R distinct positions.

Settings arrive on a synchronous register-write port with address, data and strobe, which stands in for a serial configuration link. Accepted writes go to a holding copy. The holding copy is moved into the active copy only when the group-0 count wraps back to zero, so a change never cuts a pulse short. A read port returns the active settings. Everything runs on the input clock. A ratio of one is the only case where the input clock passes through to an output, gated by that group's enable.

Top module: `cdiv_dual`

## Requirements
- R1: For a group with active ratio R > 1, the output repeats every R input cycles. It is high for R/2 cycles when R is even, and for 2 of the 5 cycles when R = 5, starting at the cycle its count returns to zero.
- R2: Register 0 (bits 3:0) sets the group-0 ratio index and register 1 (bits 3:0) sets the group-1 ratio index. Indices 0 to 10 select ratios 1, 2, 4, 5, 8, 10, 16, 20, 32, 40, 80 in that order.
- R3: A write is discarded and changes no setting if any of these holds: a ratio write carries an index above 10 or nonzero bits 7:4; a phase write has bits 7:6 set; an enable write has bits 7:2 set.
- R4: Register 2 (bits 5:0) holds the phase value k. When settings are applied, the group-1 count is placed so that its next rising edge comes k·s input cycles after the group-0 rising edge. Here n = R1/5 and s = 5 when R1 is a multiple of 5, and n = R1 and s = 1 otherwise.
- R5: A phase value of n or more is reduced modulo n before use.
- R6: With ratio 1 (index 0) a group's output equals the input clock ANDed with its enable, and the phase value has no effect on it.
- R7: Register 3 bit 0 enables group 0 and bit 1 enables group 1. A disabled group's output stays low.
- R8: Accepted writes take effect together at the first clock edge on which the group-0 count wraps to zero after the write edge. Until then the old settings stay active.
- R9: The read port returns the active setting at address rd_addr_i, using the same field layout as the writes, with unused bits zero.
- R10: After reset both ratio indices are 1 (ratio 2), the phase is 0, both enables are 1, both counts are 0 and no update is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 2 | Read-back address |
| rd_data_o | output | 8 | Active setting at rd_addr_i |
| clk0_o | output | 1 | Group-0 divided clock |
| clk1_o | output | 1 | Group-1 divided clock |

## Verification
The assertions assume that reset is held for at least one input clock edge. They also assume that the write inputs are stable around each rising edge, because the holding copy, the pending flag and the wrap detection all sample on that edge. The stimulus changes every input only on the falling edge and releases reset on a falling edge after several cycles. Out-of-range writes are sent deliberately to check that they are discarded, so the assertions expect the active indices to stay legal whatever arrives on the write port.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;
  localparam int IDX_W      = 4;
  localparam int CNT_W      = 7;
  localparam int PH_W       = 6;
  localparam int NUM_RATIOS = 11;
  localparam int NUM_GRP    = 2;

  localparam logic [1:0] A_RATIO0 = 2'd0;
  localparam logic [1:0] A_RATIO1 = 2'd1;
  localparam logic [1:0] A_PHASE  = 2'd2;
  localparam logic [1:0] A_ENABLE = 2'd3;

  localparam logic [IDX_W-1:0] RST_IDX = 4'd1;

  typedef struct packed {
    logic [NUM_GRP-1:0][IDX_W-1:0] idx;
    logic [PH_W-1:0]               ph;
    logic [NUM_GRP-1:0]            en;
  } cfg_t;

  localparam cfg_t CFG_RST = '{idx: {RST_IDX, RST_IDX}, ph: '0, en: '1};

  function automatic logic [CNT_W-1:0] ratio_of(input logic [IDX_W-1:0] idx);
    case (idx)
      4'd0:    return 7'd1;
      4'd1:    return 7'd2;
      4'd2:    return 7'd4;
      4'd3:    return 7'd5;
      4'd4:    return 7'd8;
      4'd5:    return 7'd10;
      4'd6:    return 7'd16;
      4'd7:    return 7'd20;
      4'd8:    return 7'd32;
      4'd9:    return 7'd40;
      4'd10:   return 7'd80;
      default: return 7'd2;
    endcase
  endfunction

  function automatic logic idx_ok(input logic [IDX_W-1:0] idx);
    return idx < IDX_W'(NUM_RATIOS);
  endfunction

  // cycles of high time inside one output period
  function automatic logic [CNT_W-1:0] high_of(input logic [CNT_W-1:0] r);
    if (r == 7'd1) return 7'd1;
    if (r == 7'd5) return 7'd2;
    return r >> 1;
  endfunction

  function automatic logic mult5(input logic [CNT_W-1:0] r);
    return (r % 7'd5) == 7'd0;
  endfunction

  function automatic logic [CNT_W-1:0] steps_of(input logic [CNT_W-1:0] r);
    return mult5(r) ? r / 7'd5 : r;
  endfunction

  function automatic logic [CNT_W-1:0] step_len(input logic [CNT_W-1:0] r);
    return mult5(r) ? 7'd5 : 7'd1;
  endfunction

  // group-1 count at apply time so its wrap lands k*step cycles later
  function automatic logic [CNT_W-1:0] start_of(input logic [CNT_W-1:0] r,
                                                input logic [PH_W-1:0]  ph);
    logic [CNT_W-1:0] n, k, d;
    n = steps_of(r);
    k = CNT_W'(ph) % n;
    d = k * step_len(r);
    if (d == '0) return '0;
    return r - d;
  endfunction
endpackage

// File: rtl/cdiv_cfg.sv
module cdiv_cfg
  import cdiv_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              apply_i,
  output cfg_t              shadow_o,
  output cfg_t              active_o,
  output logic              pend_o,
  output logic              wr_accept_o
);
  localparam int IDX_PAD = DATA_W - IDX_W;
  localparam int PH_PAD  = DATA_W - PH_W;
  localparam int EN_PAD  = DATA_W - NUM_GRP;

  logic fits_idx, fits_ph, fits_en;
  cfg_t shadow_q, active_q;
  logic pend_q;

  assign fits_idx = (wr_data_i[DATA_W-1 -: IDX_PAD] == '0) && idx_ok(wr_data_i[IDX_W-1:0]);
  assign fits_ph  = (wr_data_i[DATA_W-1 -: PH_PAD]  == '0);
  assign fits_en  = (wr_data_i[DATA_W-1 -: EN_PAD]  == '0);

  always_comb begin
    wr_accept_o = 1'b0;
    if (wr_en_i) begin
      case (wr_addr_i)
        A_RATIO0, A_RATIO1: wr_accept_o = fits_idx;
        A_PHASE:            wr_accept_o = fits_ph;
        default:            wr_accept_o = fits_en;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= CFG_RST;
      active_q <= CFG_RST;
      pend_q   <= 1'b0;
    end else begin
      if (apply_i) active_q <= shadow_q;
      if (wr_accept_o) begin
        case (wr_addr_i)
          A_RATIO0: shadow_q.idx[0] <= wr_data_i[IDX_W-1:0];
          A_RATIO1: shadow_q.idx[1] <= wr_data_i[IDX_W-1:0];
          A_PHASE:  shadow_q.ph     <= wr_data_i[PH_W-1:0];
          default:  shadow_q.en     <= wr_data_i[NUM_GRP-1:0];
        endcase
        pend_q <= 1'b1;
      end else if (apply_i) begin
        pend_q <= 1'b0;
      end
    end
  end

  assign shadow_o = shadow_q;
  assign active_o = active_q;
  assign pend_o   = pend_q;

  // R3: a rejected write leaves the holding copy untouched
  a_r3_reject_keeps_shadow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_accept_o) |=> (shadow_q == $past(shadow_q)));

  // R8: active settings move only on an apply edge
  a_r8_active_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !apply_i |=> $stable(active_q));

  // R2: the active indices always address the ratio table
  a_r2_active_index_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_ok(active_q.idx[0]) && idx_ok(active_q.idx[1]));

  // R8: an apply clears the pending flag unless a new write lands
  a_r8_pend_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (apply_i && !wr_accept_o) |=> !pend_q);
endmodule

// File: rtl/cdiv_counter.sv
module cdiv_counter #(
  parameter int CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] ratio_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;

  assign wrap_o = (cnt_q == ratio_i - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (wrap_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt_o = cnt_q;

  // R1: the count never leaves the current period
  a_r1_count_in_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < ratio_i);

  // R1: without a load the count steps by one or wraps to zero
  a_r1_count_advances: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !wrap_o) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
endmodule

// File: rtl/cdiv_wave.sv
module cdiv_wave
  import cdiv_pkg::*;
(
  input  logic             clk_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] ratio_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             out_o
);
  logic bypass;
  logic high_phase;

  assign bypass     = (ratio_i == 7'd1);
  assign high_phase = cnt_i < high_of(ratio_i);
  assign out_o      = en_i & high_phase & (!bypass | clk_i);
endmodule

// File: rtl/cdiv_dual.sv
module cdiv_dual
  import cdiv_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              clk0_o,
  output logic              clk1_o
);
  cfg_t shadow, active;
  logic pend, wr_accept, apply;

  logic [CNT_W-1:0] ratio_g [NUM_GRP];
  logic [CNT_W-1:0] cnt_g   [NUM_GRP];
  logic [CNT_W-1:0] start_g [NUM_GRP];
  logic             wrap_g  [NUM_GRP];
  logic             out_g   [NUM_GRP];

  // settings move only when the group-0 count wraps to zero
  assign apply = pend & wrap_g[0];

  cdiv_cfg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i),
    .apply_i     (apply),
    .shadow_o    (shadow),
    .active_o    (active),
    .pend_o      (pend),
    .wr_accept_o (wr_accept)
  );

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    assign ratio_g[g] = ratio_of(active.idx[g]);
    if (g == 0) begin : g_ref
      assign start_g[g] = '0;
    end else begin : g_shift
      assign start_g[g] = start_of(ratio_of(shadow.idx[g]), shadow.ph);
    end

    cdiv_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .ratio_i    (ratio_g[g]),
      .load_i     (apply),
      .load_val_i (start_g[g]),
      .cnt_o      (cnt_g[g]),
      .wrap_o     (wrap_g[g])
    );

    cdiv_wave u_wave (
      .clk_i   (clk_i),
      .en_i    (active.en[g]),
      .ratio_i (ratio_g[g]),
      .cnt_i   (cnt_g[g]),
      .out_o   (out_g[g])
    );
  end

  assign clk0_o = out_g[0];
  assign clk1_o = out_g[1];

  always_comb begin
    case (rd_addr_i)
      A_RATIO0: rd_data_o = DATA_W'(active.idx[0]);
      A_RATIO1: rd_data_o = DATA_W'(active.idx[1]);
      A_PHASE:  rd_data_o = DATA_W'(active.ph);
      default:  rd_data_o = DATA_W'(active.en);
    endcase
  end

  // R8: an apply edge starts a fresh group-0 period
  a_r8_apply_realigns_group0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    apply |=> (cnt_g[0] == '0));

  // R7: a disabled group is silent
  a_r7_disabled_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active.en[1] |-> !clk1_o);

  // R6: at ratio 1 the group count stays at zero, so phase cannot move it
  a_r6_bypass_no_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ratio_g[1] == 7'd1) |-> (cnt_g[1] == '0));

  // R4: the group-1 load point lies inside the incoming period
  a_r4_start_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    apply |-> (start_g[1] < ratio_of(shadow.idx[1])));
endmodule

// File: tb/cdiv_dual_bench.sv
`timescale 1ns/1ps
module cdiv_dual_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       c0o, c1o;

  always #2 clk = ~clk;

  cdiv_dual u_cdiv_dual (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .clk0_o(c0o), .clk1_o(c1o)
  );

  int    vectors = 0, fails = 0;
  string cur_req = "R10";
  bit    done = 1'b0;
  int    rtab [11] = '{1, 2, 4, 5, 8, 10, 16, 20, 32, 40, 80};

  // reference state
  int m_act[2], m_sh[2], m_ph, m_sph, m_en, m_sen, m_pend, m_c[2];

  function automatic int hi_len(int r);
    if (r == 1) return 1;
    if (r == 5) return 2;
    return r / 2;
  endfunction

  task automatic cmp(string tag, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    int r0, r1, n, d, e0, e1, er;
    bit apply;
    if (!rst_n) begin
      m_act[0] = 1; m_act[1] = 1; m_sh[0] = 1; m_sh[1] = 1;
      m_ph = 0; m_sph = 0; m_en = 3; m_sen = 3; m_pend = 0;
      m_c[0] = 0; m_c[1] = 0;
    end else begin
      r0 = rtab[m_act[0]];
      apply = (m_pend != 0) && (m_c[0] == r0 - 1);
      if (apply) begin
        m_act[0] = m_sh[0]; m_act[1] = m_sh[1]; m_ph = m_sph; m_en = m_sen;
        r1 = rtab[m_act[1]];
        n = (r1 % 5 == 0) ? r1 / 5 : r1;
        d = (m_ph % n) * (r1 / n);
        m_c[0] = 0;
        m_c[1] = (r1 - d) % r1;
        m_pend = 0;
      end else begin
        m_c[0] = (m_c[0] + 1) % r0;
        m_c[1] = (m_c[1] + 1) % rtab[m_act[1]];
      end
      if (wr_en) begin
        case (wr_addr)
          2'd0, 2'd1: if (wr_data < 11) begin m_sh[wr_addr] = int'(wr_data); m_pend = 1; end
          2'd2:       if (wr_data < 64) begin m_sph = int'(wr_data); m_pend = 1; end
          default:    if (wr_data < 4)  begin m_sen = int'(wr_data); m_pend = 1; end
        endcase
      end
    end
    #1;
    // clock is high here, so a ratio-1 group shows its enable
    e0 = ((m_en & 1) != 0 && m_c[0] < hi_len(rtab[m_act[0]])) ? 1 : 0;
    e1 = ((m_en & 2) != 0 && m_c[1] < hi_len(rtab[m_act[1]])) ? 1 : 0;
    case (rd_addr)
      2'd0: er = m_act[0];
      2'd1: er = m_act[1];
      2'd2: er = m_ph;
      default: er = m_en;
    endcase
    cmp(cur_req, "clk0_o", int'(c0o), e0);
    cmp(cur_req, "clk1_o", int'(c1o), e1);
    cmp((cur_req == "R10") ? "R10" : "R9", "rd_data_o", int'(rd_data), er);
  end

  initial begin
    forever begin
      @(negedge clk);
      rd_addr = rd_addr + 2'd1;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    // R10: reset values observed during and after reset
    idle(4);
    rst_n = 1'b1;
    idle(12);

    // R2: every table entry on both groups
    cur_req = "R2";
    for (int i = 0; i < 11; i++) begin
      wr(2'd0, 8'(i));
      wr(2'd1, 8'(10 - i));
      idle(180);
    end

    // R1: odd ratio 5 duty and even ratios
    cur_req = "R1";
    wr(2'd0, 8'd3); wr(2'd1, 8'd2); idle(120);
    wr(2'd1, 8'd3); idle(120);
    wr(2'd0, 8'd9); wr(2'd1, 8'd5); idle(200);

    // R3: out-of-range writes leave the settings alone
    cur_req = "R3";
    wr(2'd0, 8'd13); idle(100);
    wr(2'd1, 8'h15); idle(100);
    wr(2'd2, 8'h41); idle(100);
    wr(2'd3, 8'h06); idle(100);

    // R4: step of 5 cycles at ratio 80, step of 1 at 16 and 8
    cur_req = "R4";
    wr(2'd0, 8'd1); wr(2'd1, 8'd10);
    foreach (rtab[j]) if (j < 4) begin wr(2'd2, 8'(j * 5)); idle(200); end
    wr(2'd1, 8'd6); wr(2'd2, 8'd3); idle(100);
    wr(2'd2, 8'd9); idle(100);
    wr(2'd1, 8'd4); wr(2'd2, 8'd5); idle(100);

    // R5: phase values past the step count wrap
    cur_req = "R5";
    wr(2'd1, 8'd10); wr(2'd2, 8'd16); idle(200);
    wr(2'd2, 8'd21); idle(200);
    wr(2'd2, 8'd63); idle(200);
    wr(2'd1, 8'd7); wr(2'd2, 8'd6); idle(100);

    // R6: ratio 1 passes the clock, phase ignored
    cur_req = "R6";
    wr(2'd1, 8'd0); wr(2'd2, 8'd9); idle(40);
    wr(2'd0, 8'd0); idle(40);
    wr(2'd2, 8'd2); idle(40);

    // R7: enable combinations
    cur_req = "R7";
    wr(2'd0, 8'd2);
    wr(2'd3, 8'd0); idle(40);
    wr(2'd3, 8'd1); idle(40);
    wr(2'd3, 8'd2); idle(40);
    wr(2'd3, 8'd3); idle(40);

    // R8: old settings persist until the group-0 wrap
    cur_req = "R8";
    wr(2'd0, 8'd10); idle(200);
    wr(2'd1, 8'd5); idle(30);
    wr(2'd0, 8'd2); idle(200);

    cur_req = "R9";
    idle(50);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule